// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is an SPI mode-0 slave that answers like a 512-byte serial EEPROM. A host selects it with an active-low chip select. The host clocks command, address and data bytes in on the serial input and receives bytes on the serial output. The storage is an internal register array.

Writes are gated by a write-enable latch. Data bytes go into a four-byte page buffer whose two low address bits wrap. Nothing reaches the array until chip select is released cleanly on a byte boundary. That release starts a programming phase, which lasts a parameterized number of system clock cycles. The status register shows a busy flag, the latch and two block-protect bits. A host polls the status register to learn when programming has ended.

The SPI inputs are sampled with the system clock. The serial clock must therefore run several times slower than the system clock.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every memory byte reads 0x00 and `so_oe` is low.
- R2: SI is captured on SCK rising edges, MSB first. SO changes on SCK falling edges, MSB first. `so_oe` is high exactly while `cs_n` is low.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Status bit 1 mirrors the latch.
- R4: Opcode 0x05 returns the status byte {0000, bp1, bp0, latch, busy} for every byte clocked after it, refreshed at each byte.
- R5: Opcode 0000_A011, where bit 3 carries address bit 8, is followed by the low address byte. It then streams memory bytes from that address upward, wrapping from 0x1FF to 0x000.
- R6: Opcode 0000_A010 with the latch set takes an address, then data bytes into a 4-byte page. Each data byte advances only address bits 1:0, modulo 4. Bits 8:2 stay fixed, and a fifth or later byte overwrites an earlier page slot.
- R7: A write opcode received while the latch is clear is ignored. No busy cycle follows and memory is unchanged.
- R8: Programming starts only when `cs_n` rises while SCK is low, after a whole number of bytes and with at least one data byte received. Any other release aborts the operation: nothing is written and the latch is unchanged.
- R9: Status bit 0 is 1 for PROG_CYCLES system clocks after a valid release. The buffered bytes are committed when it falls.
- R10: While busy, every opcode except 0x05 is ignored.
- R11: The latch clears when any write or status-write programming cycle completes.
- R12: Opcode 0x01 is accepted only with the latch set and `wp_n` high. Of its data byte, only bits 3 and 2 become bp1 and bp0 after programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Status write permit (high allows) |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (high drives) |

## Verification
Every output bit is due on the SCK falling edge that follows the rising edge of the previous bit, plus two system clocks of input sampling. The bench therefore reads SO four clocks after its own falling edge, just before it raises SCK again. Status and memory effects of a write are due PROG_CYCLES clocks after the release is sampled. The first status frame after a release must still show busy, because two byte times are shorter than the programming window. From then on the bench polls status until bit 0 clears before it reads memory back.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] LO_READ      = 3'b011;
  localparam logic [2:0] LO_WRITE     = 3'b010;

  typedef enum logic [2:0] {
    FR_OPCODE, FR_ADDR, FR_DATA, FR_READ, FR_STAT, FR_SRDATA, FR_SKIP
  } frame_e;

  function automatic logic [7:0] status_byte(input logic [1:0] bp, input logic wel,
                                             input logic busy);
    return {4'b0000, bp, wel, busy};
  endfunction

  function automatic logic mem_op(input logic [7:0] op, input logic [2:0] lo);
    return (op[7:4] == 4'h0) && (op[2:0] == lo);
  endfunction
endpackage

// File: rtl/spi_ee_edges.sv
module spi_ee_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_n_s,
  output logic sck_s,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_s <= 1'b1; cs_d <= 1'b1;
      sck_s  <= 1'b0; sck_d <= 1'b0;
      si_s   <= 1'b0;
    end else begin
      cs_n_s <= cs_n_i; cs_d <= cs_n_s;
      sck_s  <= sck_i;  sck_d <= sck_s;
      si_s   <= si_i;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_n_s & ~cs_d;
endmodule

// File: rtl/spi_ee_rx.sv
module spi_ee_rx #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sck_rise,
  input  logic                 si_s,
  output logic                 byte_done,
  output logic [W-1:0]         rx_byte,
  output logic [$clog2(W)-1:0] bit_cnt
);
  localparam int CW = $clog2(W);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bit_cnt <= '0;
    end else if (cs_n_s) begin
      sh <= '0; bit_cnt <= '0;
    end else if (sck_rise) begin
      sh      <= {sh[W-2:0], si_s};
      bit_cnt <= (bit_cnt == CW'(W-1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign byte_done = ~cs_n_s & sck_rise & (bit_cnt == CW'(W-1));
  assign rx_byte   = {sh[W-2:0], si_s};
endmodule

// File: rtl/spi_ee_prog_timer.sv
module spi_ee_prog_timer #(
  parameter int CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
  parameter int PAGE_BYTES  = 4,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  import spi_ee_pkg::*;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int HI_W  = AW - PG_W;

  function automatic logic [AW-1:0] page_inc(input logic [AW-1:0] a);
    logic [PG_W-1:0] lo;
    lo = a[PG_W-1:0] + 1'b1;
    return {a[AW-1:PG_W], lo};
  endfunction

  logic cs_n_s, sck_s, si_s, sck_rise, sck_fall, cs_rise;
  logic byte_done;
  logic [7:0] rx_byte;
  logic [2:0] bit_cnt;
  logic busy, prog_done;

  spi_ee_edges edges_i (.clk, .rst_n, .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
    .cs_n_s, .sck_s, .si_s, .sck_rise, .sck_fall, .cs_rise);
  spi_ee_rx #(.W(8)) rx_i (.clk, .rst_n, .cs_n_s, .sck_rise, .si_s,
    .byte_done, .rx_byte, .bit_cnt);

  frame_e          fstate;
  logic [7:0]      mem [DEPTH];
  logic [7:0]      pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [AW-1:0]   addr;
  logic [HI_W-1:0] pg_base;
  logic            a8, is_write, wel, pend_wr, pend_sr, commit_wr;
  logic [1:0]      bp, bp_new;
  logic [7:0]      tx_sh;
  logic            so_q;

  // named events
  logic op_byte, data_take, sr_take, pend_any, prog_start, sr_commit;
  assign op_byte    = byte_done && (fstate == FR_OPCODE);
  assign data_take  = byte_done && (fstate == FR_DATA);
  assign sr_take    = byte_done && (fstate == FR_SRDATA);
  assign pend_any   = pend_wr | pend_sr;
  assign prog_start = cs_rise && pend_any && (bit_cnt == 3'd0) && !sck_s;
  assign sr_commit  = prog_done && !commit_wr;

  spi_ee_prog_timer #(.CYC(PROG_CYCLES)) timer_i (.clk, .rst_n, .start(prog_start),
    .busy, .done(prog_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstate <= FR_OPCODE; addr <= '0; pg_base <= '0; a8 <= 1'b0;
      is_write <= 1'b0; wel <= 1'b0; pend_wr <= 1'b0; pend_sr <= 1'b0;
      commit_wr <= 1'b0; bp <= 2'b00; bp_new <= 2'b00; pmask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (cs_rise) begin
        fstate <= FR_OPCODE; pend_wr <= 1'b0; pend_sr <= 1'b0;
        if (prog_start) begin
          commit_wr <= pend_wr;
          pg_base   <= addr[AW-1:PG_W];
        end
      end else if (byte_done) begin
        unique case (fstate)
          FR_OPCODE: begin
            fstate <= FR_SKIP;
            if (!busy || rx_byte == OP_STAT_RD) begin
              if (rx_byte == OP_LATCH_ON)       wel <= 1'b1;
              else if (rx_byte == OP_LATCH_OFF) wel <= 1'b0;
              else if (rx_byte == OP_STAT_RD)   fstate <= FR_STAT;
              else if (rx_byte == OP_STAT_WR) begin
                if (wel && wp_n) fstate <= FR_SRDATA;
              end else if (mem_op(rx_byte, LO_READ)) begin
                a8 <= rx_byte[3]; is_write <= 1'b0; fstate <= FR_ADDR;
              end else if (mem_op(rx_byte, LO_WRITE) && wel) begin
                a8 <= rx_byte[3]; is_write <= 1'b1; fstate <= FR_ADDR; pmask <= '0;
              end
            end
          end
          FR_ADDR: begin
            addr   <= {a8, rx_byte};
            fstate <= is_write ? FR_DATA : FR_READ;
          end
          FR_DATA: begin
            pbuf[addr[PG_W-1:0]]  <= rx_byte;
            pmask[addr[PG_W-1:0]] <= 1'b1;
            addr    <= page_inc(addr);
            pend_wr <= 1'b1;
          end
          FR_SRDATA: begin
            bp_new  <= rx_byte[3:2];
            pend_sr <= 1'b1;
            fstate  <= FR_SKIP;
          end
          FR_READ: addr <= addr + 1'b1;
          default: ;
        endcase
      end
      if (prog_done) begin
        wel <= 1'b0;
        if (commit_wr) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pmask[i]) mem[{pg_base, PG_W'(i)}] <= pbuf[i];
        end else begin
          bp <= bp_new;
        end
      end
    end
  end

  // output shifter: load at byte end, shift on falling SCK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= 8'h00; so_q <= 1'b0;
    end else if (cs_n_s) begin
      tx_sh <= 8'h00; so_q <= 1'b0;
    end else if (byte_done) begin
      if ((fstate == FR_OPCODE && rx_byte == OP_STAT_RD) || fstate == FR_STAT)
        tx_sh <= status_byte(bp, wel, busy);
      else if (fstate == FR_ADDR && !is_write)
        tx_sh <= mem[{a8, rx_byte}];
      else if (fstate == FR_READ)
        tx_sh <= mem[addr + 1'b1];
      else
        tx_sh <= 8'h00;
    end else if (sck_fall) begin
      so_q  <= tx_sh[7];
      tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign so    = so_q;
  assign so_oe = ~cs_n;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int PROG_CYCLES = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       prog_done,
  input logic       wel,
  input logic [2:0] bit_cnt,
  input logic       pend_any,
  input logic       data_take,
  input logic [8:0] addr,
  input logic       sr_take,
  input logic       sr_commit,
  input logic [1:0] bp
);
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (!busy) busy_len <= '0;
    else           busy_len <= busy_len + 1;
  end

  assert_latch_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !prog_done |=> wel == $past(wel));
  assert_latch_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wel);
  assert_start_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bit_cnt) == 3'd0) && $past(pend_any));
  assert_page_high_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> addr[8:2] == $past(addr[8:2]));
  assert_page_low_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> addr[1:0] == 2'($past(addr[1:0]) + 2'd1));
  assert_sr_needs_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sr_take |-> wel);
  assert_bp_only_on_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |=> $stable(bp));
  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> busy_len == 32'(PROG_CYCLES - 1));
endmodule

bind spi_ee_slave spi_ee_checker #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prog_done(prog_done), .wel(wel),
  .bit_cnt(bit_cnt), .pend_any(pend_any), .data_take(data_take), .addr(addr),
  .sr_take(sr_take), .sr_commit(sr_commit), .bp(bp));

// File: tb/spi_ee_slave_tb.sv
module spi_ee_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_mem [512];
  logic [1:0] exp_bp = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ee_slave dut_i (.clk, .rst_n, .cs_n, .sck, .si, .wp_n, .so, .so_oe);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic [1:0] bp, input logic wel, input logic bsy);
    return {4'b0, bp, wel, bsy};
  endfunction

  function automatic logic [8:0] slot(input logic [8:0] a, input int k);
    logic [1:0] lo;
    lo = a[1:0] + 2'(k);
    return {a[8:2], lo};
  endfunction

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk); cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rd_stat(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int t = 0; t < 100; t++) begin
      rd_stat(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] d [8]);
    logic [7:0] r;
    sel();
    xfer({4'b0, a[8], 3'b010}, r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(d[k], r);
    desel();
  endtask

  task automatic read_chk(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    logic [8:0] p;
    sel();
    xfer({4'b0, a[8], 3'b011}, r);
    xfer(a[7:0], r);
    p = a;
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(req, r, exp_mem[p]);
      p = p + 9'd1;
    end
    desel();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] s, r;
    logic [7:0] d [8];
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 so_oe idle", {7'b0, so_oe}, 8'h00);
    rd_stat(s); chk("R1 status", s, 8'h00);
    read_chk(9'h000, 2, "R1 memory");

    // R2 output enable follows select
    sel(); chk("R2 so_oe selected", {7'b0, so_oe}, 8'h01);
    xfer(8'hFF, r); desel();
    chk("R2 so_oe released", {7'b0, so_oe}, 8'h00);

    // R3 latch set / clear
    cmd1(8'h06); rd_stat(s); chk("R3 latch on", s, stat(2'b00, 1, 0));
    cmd1(8'h04); rd_stat(s); chk("R3 latch off", s, stat(2'b00, 0, 0));

    // R7 write without latch
    d[0] = 8'hAA;
    do_write(9'h010, 1, d);
    rd_stat(s); chk("R7 no busy", s, 8'h00);
    read_chk(9'h010, 1, "R7 memory unchanged");

    // R6 R9 R11 page wrap with six bytes
    cmd1(8'h06);
    for (int k = 0; k < 6; k++) d[k] = 8'hC0 + 8'(k);
    do_write(9'h1F2, 6, d);
    for (int k = 0; k < 6; k++) exp_mem[slot(9'h1F2, k)] = d[k];
    rd_stat(s); chk("R9 busy after release", s, stat(2'b00, 1, 1));
    chk("R4 status repeat", s, stat(2'b00, 1, 1));
    wait_ready();
    rd_stat(s); chk("R11 latch cleared", s, 8'h00);
    read_chk(9'h1F0, 5, "R6 page wrap");

    // R10 opcode other than status read ignored while busy
    cmd1(8'h06);
    d[0] = 8'h5A;
    do_write(9'h020, 1, d); exp_mem[9'h020] = 8'h5A;
    cmd1(8'h04);
    rd_stat(s); chk("R10 latch-off ignored while busy", s, stat(2'b00, 1, 1));
    wait_ready();
    rd_stat(s); chk("R11 cleared after write", s, 8'h00);
    read_chk(9'h020, 1, "R9 committed");

    // R8 early release mid-byte
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h30, r); xfer(8'h55, r); bits(8'hFF, 3, r); desel();
    rd_stat(s); chk("R8 abort not busy", s, stat(2'b00, 1, 0));
    read_chk(9'h030, 1, "R8 abort memory");
    cmd1(8'h04);

    // R12 status write guarded by wp_n
    cmd1(8'h06); wp_n = 1'b0;
    sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
    rd_stat(s); chk("R12 wp low ignored", s, stat(2'b00, 1, 0));
    wp_n = 1'b1;
    sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
    wait_ready(); exp_bp = 2'b11;
    rd_stat(s); chk("R12 bp set", s, stat(exp_bp, 0, 0));
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'hF3, r); desel();
    wait_ready(); exp_bp = 2'b00;
    rd_stat(s); chk("R12 dont-care bits", s, stat(exp_bp, 0, 0));

    // R6 R9 random page writes
    for (int t = 0; t < 6; t++) begin
      logic [8:0] a;
      int n;
      a = 9'($urandom % 512);
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) d[k] = 8'($urandom);
      cmd1(8'h06);
      do_write(a, n, d);
      for (int k = 0; k < n; k++) exp_mem[slot(a, k)] = d[k];
      wait_ready();
      read_chk({a[8:2], 2'b00}, 4, "R6 random page");
    end

    // R5 streaming read across top of memory
    cmd1(8'h06);
    d[0] = 8'h9E; d[1] = 8'h11;
    do_write(9'h1FF, 1, d); exp_mem[9'h1FF] = 8'h9E;
    wait_ready();
    cmd1(8'h06);
    do_write(9'h000, 1, d[1:1] == d[1:1] ? '{8'h11, 0, 0, 0, 0, 0, 0, 0} : d);
    exp_mem[9'h000] = 8'h11;
    wait_ready();
    read_chk(9'h1FE, 4, "R5 address wrap");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule